// File: doc/BRIEF.md
# Register-Held Transmit/Receive Descriptor Ring Engine

This block holds the buffer descriptors of a simple Ethernet MAC in flip-flops rather than in system memory. Each direction has a ring of four slots. Every slot carries a buffer word (buffer address plus control flags) and a captured status word. Transmit slots also carry a frame length. Software arms a slot by writing the buffer address with the enable flag set. The engine serves slots strictly in ring order. When the MAC side signals the end of a frame, the engine marks the slot done, drops its enable flag and stores the frame status.

The bus transfers and the serialiser are outside the block. On the transmit side the block offers the current slot's address and length with a request level, and accepts a completion strobe together with a status word. On the receive side it shows whether the current slot is ready and accepts a frame-arrival strobe with the received status. A frame that arrives while the current slot is not armed is counted as missed. Software learns the engine's position from the ring-index field that every buffer word returns on a read. It acknowledges a finished slot by clearing its done flag. A level interrupt combines the done flags of both rings with an enable bit.

Top module: `dring_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every buffer word, length, status word and ring index reads 0, the missed counter reads 0, the interrupt enable is 0, and `irq_o`, `tx_req_o` and `rx_rdy_o` are low.
- R2: A buffer word reads back as {address[31:4], ring index[3:2], done[1], enable[0]}, where bits [3:2] give the slot the engine of that ring will serve next. A write stores bits [31:4] and sets enable to wdata[0]. When wdata[0]=1 it clears done. When wdata[0]=0 it keeps done only if wdata[1]=1.
- R3: `tx_req_o` is high exactly when the current transmit slot is enabled. While it is high, `tx_addr_o` equals that slot's address with bits [3:0] zero, and `tx_len_o` equals that slot's length register.
- R4: A `tx_cmpl_i` pulse while `tx_req_o` is high clears enable, sets done, stores `tx_stat_i` in the current slot and advances the transmit index by one. A pulse while `tx_req_o` is low changes nothing.
- R5: The transmit engine never passes a slot that is not armed. If the current slot is not armed, `tx_req_o` stays low and the index holds, even when later slots are armed.
- R6: An `rx_frm_i` pulse while `rx_rdy_o` is high stores all 32 bits of `rx_stat_i` in the current receive slot, with no change to the frame length field (which includes the 4-byte FCS). The pulse also clears enable, sets done and advances the receive index.
- R7: An `rx_frm_i` pulse while `rx_rdy_o` is low leaves every slot and the receive index unchanged and adds one to the missed counter. The counter saturates at 255.
- R8: No slot is ever both enabled and done.
- R9: `irq_o` is high exactly when the interrupt enable (bit 0 of the control register) is 1 and at least one slot of either ring has done set.
- R10: Register address = {group[4:2], slot[1:0]}. The groups are: 0 transmit buffer word, 1 transmit length (11 bits), 2 transmit status, 3 receive buffer word, 4 receive status, 5 control (slot 0: interrupt enable in bit 0; slot 1: missed counter, read-only). Writes to the status groups or to the missed counter have no effect.
- R11: Both ring indices wrap from slot 3 back to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_req_o | output | 1 | Current transmit slot is armed |
| tx_addr_o | output | 32 | Buffer address of current transmit slot |
| tx_len_o | output | 11 | Frame length of current transmit slot |
| tx_cmpl_i | input | 1 | Transmit frame finished strobe |
| tx_stat_i | input | 32 | Transmit status captured on completion |
| rx_rdy_o | output | 1 | Current receive slot is armed |
| rx_addr_o | output | 32 | Buffer address of current receive slot |
| rx_frm_i | input | 1 | Received frame finished strobe |
| rx_stat_i | input | 32 | Receive status (length incl. FCS, error flags) |
| irq_o | output | 1 | Level interrupt |

## Verification
The first pattern arms one transmit slot at a time and completes it. This checks how the request, address, length and index follow a single slot, and how the done flag drives the interrupt. A second pattern arms a slot ahead of an idle one and sends stray completions; it tells an engine that waits apart from one that skips or advances on a stray pulse. On the receive side, frames are sent into a fully armed ring, then into an exhausted ring, then in a long burst with nothing armed. This tells status capture apart from missed counting and from counter saturation. Writes that set or clear the done flag, and writes aimed at read-only addresses, check the acknowledge rules and the register map.

// File: rtl/dring_pkg.sv
// Shared definitions for the descriptor ring engine.
// Assumes a 3-bit register group field above the slot field.
package dring_pkg;
    typedef enum logic [2:0] {
        G_TXBUF  = 3'd0,
        G_TXLEN  = 3'd1,
        G_TXSTAT = 3'd2,
        G_RXBUF  = 3'd3,
        G_RXSTAT = 3'd4,
        G_CTRL   = 3'd5
    } grp_e;

    localparam int EN_BIT   = 0;
    localparam int DONE_BIT = 1;
    localparam int CTRL_SLOT = 0;
    localparam int MISS_SLOT = 1;
endpackage

// File: rtl/dring_satcnt.sv
// Saturating event counter.
// Assumes inc is a single-cycle pulse per event; holds at all-ones.
module dring_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt_o
);
    // Count events, stopping at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (inc && (cnt_o != {W{1'b1}}))
            cnt_o <= cnt_o + W'(1);
    end
endmodule

// File: rtl/dring_ring.sv
// One ring of register-held descriptors with its service index.
// Serves slots strictly in order; a hardware event on the current
// slot takes precedence over a software write to that slot's buffer
// word in the same cycle. NSLOT must be a power of two, at most 4.
module dring_ring #(
    parameter int NSLOT   = 4,
    parameter int DW      = 32,
    parameter int LW      = 11,
    parameter bit HAS_LEN = 1'b1,
    localparam int IW     = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_buf,
    input  logic             wr_len,
    input  logic [IW-1:0]    wr_slot,
    input  logic [DW-1:0]    wr_data,
    input  logic             evt_i,
    input  logic [DW-1:0]    evt_stat_i,
    input  logic [IW-1:0]    rd_slot,
    output logic [DW-1:0]    rd_buf_o,
    output logic [LW-1:0]    rd_len_o,
    output logic [DW-1:0]    rd_stat_o,
    output logic [IW-1:0]    head_o,
    output logic             head_en_o,
    output logic [DW-1:0]    head_addr_o,
    output logic [LW-1:0]    head_len_o,
    output logic             miss_o,
    output logic [NSLOT-1:0] en_v_o,
    output logic [NSLOT-1:0] done_v_o
);
    logic [DW-5:0] addr_q [NSLOT];
    logic [LW-1:0] len_q  [NSLOT];
    logic [DW-1:0] stat_q [NSLOT];
    logic [NSLOT-1:0] en_q, done_q;
    logic [IW-1:0] head_q;
    logic hit;

    assign hit    = evt_i &  en_q[head_q];
    assign miss_o = evt_i & ~en_q[head_q];

    // Advance the service index on each accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            head_q <= '0;
        else if (hit)
            head_q <= head_q + IW'(1);
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic sel_hw, sel_sw;
        assign sel_hw = hit && (head_q == IW'(s));
        assign sel_sw = wr_buf && (wr_slot == IW'(s));

        // Slot buffer word and status: hardware completion first, then software.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[s] <= '0;
                en_q[s]   <= 1'b0;
                done_q[s] <= 1'b0;
                stat_q[s] <= '0;
            end else if (sel_hw) begin
                en_q[s]   <= 1'b0;
                done_q[s] <= 1'b1;
                stat_q[s] <= evt_stat_i;
            end else if (sel_sw) begin
                addr_q[s] <= wr_data[DW-1:4];
                en_q[s]   <= wr_data[dring_pkg::EN_BIT];
                done_q[s] <= done_q[s] & wr_data[dring_pkg::DONE_BIT]
                             & ~wr_data[dring_pkg::EN_BIT];
            end
        end

        if (HAS_LEN) begin : g_len
            // Frame length written by software.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    len_q[s] <= '0;
                else if (wr_len && (wr_slot == IW'(s)))
                    len_q[s] <= wr_data[LW-1:0];
            end
        end else begin : g_nolen
            assign len_q[s] = '0;
        end
    end

    assign rd_buf_o    = {addr_q[rd_slot], 2'(head_q), done_q[rd_slot], en_q[rd_slot]};
    assign rd_len_o    = len_q[rd_slot];
    assign rd_stat_o   = stat_q[rd_slot];
    assign head_o      = head_q;
    assign head_en_o   = en_q[head_q];
    assign head_addr_o = {addr_q[head_q], 4'b0000};
    assign head_len_o  = len_q[head_q];
    assign en_v_o      = en_q;
    assign done_v_o    = done_q;
endmodule

// File: rtl/dring_ctrl.sv
// Top of the descriptor ring engine: register decode, two rings,
// missed-frame counter and level interrupt.
// Assumes one register access per cycle; reads are combinational.
module dring_ctrl #(
    parameter int NSLOT = 4,
    parameter int DW    = 32,
    parameter int LW    = 11,
    parameter int MW    = 8,
    localparam int IW   = $clog2(NSLOT),
    localparam int AW   = 3 + IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          tx_req_o,
    output logic [DW-1:0] tx_addr_o,
    output logic [LW-1:0] tx_len_o,
    input  logic          tx_cmpl_i,
    input  logic [DW-1:0] tx_stat_i,
    output logic          rx_rdy_o,
    output logic [DW-1:0] rx_addr_o,
    input  logic          rx_frm_i,
    input  logic [DW-1:0] rx_stat_i,
    output logic          irq_o
);
    import dring_pkg::*;

    grp_e          grp;
    logic [IW-1:0] slot;
    logic          irq_en;
    logic [DW-1:0] tx_rbuf, tx_rstat, rx_rbuf, rx_rstat;
    logic [LW-1:0] tx_rlen, rx_rlen, rx_hlen;
    logic [IW-1:0] tx_head, rx_head;
    logic [NSLOT-1:0] tx_en_v, tx_done_v, rx_en_v, rx_done_v;
    logic          tx_miss, rx_miss;
    logic [MW-1:0] miss_cnt;

    assign grp  = grp_e'(reg_addr[AW-1:IW]);
    assign slot = reg_addr[IW-1:0];

    dring_ring #(.NSLOT(NSLOT), .DW(DW), .LW(LW), .HAS_LEN(1'b1)) u_tx (
        .clk, .rst_n,
        .wr_buf(reg_wr && grp == G_TXBUF), .wr_len(reg_wr && grp == G_TXLEN),
        .wr_slot(slot), .wr_data(reg_wdata),
        .evt_i(tx_cmpl_i), .evt_stat_i(tx_stat_i), .rd_slot(slot),
        .rd_buf_o(tx_rbuf), .rd_len_o(tx_rlen), .rd_stat_o(tx_rstat),
        .head_o(tx_head), .head_en_o(tx_req_o), .head_addr_o(tx_addr_o),
        .head_len_o(tx_len_o), .miss_o(tx_miss),
        .en_v_o(tx_en_v), .done_v_o(tx_done_v));

    dring_ring #(.NSLOT(NSLOT), .DW(DW), .LW(LW), .HAS_LEN(1'b0)) u_rx (
        .clk, .rst_n,
        .wr_buf(reg_wr && grp == G_RXBUF), .wr_len(1'b0),
        .wr_slot(slot), .wr_data(reg_wdata),
        .evt_i(rx_frm_i), .evt_stat_i(rx_stat_i), .rd_slot(slot),
        .rd_buf_o(rx_rbuf), .rd_len_o(rx_rlen), .rd_stat_o(rx_rstat),
        .head_o(rx_head), .head_en_o(rx_rdy_o), .head_addr_o(rx_addr_o),
        .head_len_o(rx_hlen), .miss_o(rx_miss),
        .en_v_o(rx_en_v), .done_v_o(rx_done_v));

    dring_satcnt #(.W(MW)) u_miss (
        .clk, .rst_n, .inc(rx_miss), .cnt_o(miss_cnt));

    // Interrupt enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en <= 1'b0;
        else if (reg_wr && grp == G_CTRL && slot == IW'(CTRL_SLOT))
            irq_en <= reg_wdata[0];
    end

    assign irq_o = irq_en & ((|tx_done_v) | (|rx_done_v));

    // Read-data multiplexer over the register groups.
    always_comb begin
        reg_rdata = '0;
        case (grp)
            G_TXBUF:  reg_rdata = tx_rbuf;
            G_TXLEN:  reg_rdata = DW'(tx_rlen);
            G_TXSTAT: reg_rdata = tx_rstat;
            G_RXBUF:  reg_rdata = rx_rbuf;
            G_RXSTAT: reg_rdata = rx_rstat;
            G_CTRL: begin
                if (slot == IW'(CTRL_SLOT))      reg_rdata = DW'(irq_en);
                else if (slot == IW'(MISS_SLOT)) reg_rdata = DW'(miss_cnt);
            end
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dring_ctrl_chk.sv
// Property checker for dring_ctrl, attached by bind.
// Assumes the synchronous active-low reset is held for at least one edge.
module dring_ctrl_chk #(
    parameter int NSLOT = 4,
    parameter int MW    = 8,
    localparam int IW   = $clog2(NSLOT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSLOT-1:0] tx_en_v,
    input logic [NSLOT-1:0] tx_done_v,
    input logic [NSLOT-1:0] rx_en_v,
    input logic [NSLOT-1:0] rx_done_v,
    input logic [IW-1:0]    tx_head,
    input logic [IW-1:0]    rx_head,
    input logic             tx_req_o,
    input logic             tx_cmpl_i,
    input logic             rx_rdy_o,
    input logic             rx_frm_i,
    input logic [MW-1:0]    miss_cnt,
    input logic             irq_en,
    input logic             irq_o
);
    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_en_v & tx_done_v) == '0) && ((rx_en_v & rx_done_v) == '0));

    assert_tx_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cmpl_i && tx_req_o) |=> (tx_head == IW'($past(tx_head) + IW'(1))));

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cmpl_i && !tx_req_o) |=> $stable(tx_head));

    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frm_i && !rx_rdy_o) |=> ($stable(rx_head) && $stable(rx_done_v)));

    assert_miss_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frm_i && !rx_rdy_o && miss_cnt != {MW{1'b1}})
        |=> (miss_cnt == MW'($past(miss_cnt) + MW'(1))));

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);
endmodule

bind dring_ctrl dring_ctrl_chk #(.NSLOT(NSLOT), .MW(MW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_en_v(tx_en_v), .tx_done_v(tx_done_v),
    .rx_en_v(rx_en_v), .rx_done_v(rx_done_v),
    .tx_head(tx_head), .rx_head(rx_head),
    .tx_req_o(tx_req_o), .tx_cmpl_i(tx_cmpl_i),
    .rx_rdy_o(rx_rdy_o), .rx_frm_i(rx_frm_i),
    .miss_cnt(miss_cnt), .irq_en(irq_en), .irq_o(irq_o));

// File: tb/dring_ctrl_tb.sv
`timescale 1ns/1ps
// Self-checking bench with a behavioural reference model of both rings.
module dring_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_req_o, rx_rdy_o, irq_o;
    logic [31:0] tx_addr_o, rx_addr_o;
    logic [10:0] tx_len_o;
    logic        tx_cmpl_i = 1'b0, rx_frm_i = 1'b0;
    logic [31:0] tx_stat_i = '0, rx_stat_i = '0;

    always #4 clk = ~clk;

    dring_ctrl u_dut (.*);

    int checks = 0, fails = 0;
    bit finished = 0;

    // Reference model state (state after the most recent edge)
    logic [31:0] m_ta[4], m_ra[4], m_ts[4], m_rs[4];
    int          m_tl[4];
    bit          m_ten[4], m_tdn[4], m_ren[4], m_rdn[4];
    int          m_th = 0, m_rh = 0, m_miss = 0;
    bit          m_ie = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit any_done();
        for (int i = 0; i < 4; i++) if (m_tdn[i] || m_rdn[i]) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] buf_word(input bit tx, input int s);
        if (tx) return m_ta[s] | (32'(m_th) << 2) | (32'(m_tdn[s]) << 1) | 32'(m_ten[s]);
        return m_ra[s] | (32'(m_rh) << 2) | (32'(m_rdn[s]) << 1) | 32'(m_ren[s]);
    endfunction

    // Compare all outputs against the model once per cycle.
    task automatic compare();
        chk("R3 tx_req_o", 32'(tx_req_o), 32'(m_ten[m_th]));
        chk("R3 tx_addr_o", tx_addr_o, m_ta[m_th]);
        chk("R3 tx_len_o", 32'(tx_len_o), 32'(m_tl[m_th]));
        chk("R6 rx_rdy_o", 32'(rx_rdy_o), 32'(m_ren[m_rh]));
        chk("R6 rx_addr_o", rx_addr_o, m_ra[m_rh]);
        chk("R9 irq_o", 32'(irq_o), 32'(m_ie && any_done()));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        int g = a >> 2, s = a & 3;
        reg_wr = 1; reg_addr = 5'(a); reg_wdata = d;
        case (g)
            0: begin
                m_ta[s] = d & 32'hFFFF_FFF0;
                m_tdn[s] = d[0] ? 0 : (m_tdn[s] && d[1]);
                m_ten[s] = d[0];
            end
            1: m_tl[s] = int'(d[10:0]);
            3: begin
                m_ra[s] = d & 32'hFFFF_FFF0;
                m_rdn[s] = d[0] ? 0 : (m_rdn[s] && d[1]);
                m_ren[s] = d[0];
            end
            5: if (s == 0) m_ie = d[0];
            default: ;
        endcase
        tick();
        reg_wr = 0;
    endtask

    task automatic tx_done(input logic [31:0] st);
        tx_cmpl_i = 1; tx_stat_i = st;
        if (m_ten[m_th]) begin
            m_ten[m_th] = 0; m_tdn[m_th] = 1; m_ts[m_th] = st; m_th = (m_th + 1) % 4;
        end
        tick();
        tx_cmpl_i = 0;
    endtask

    task automatic rx_frm(input logic [31:0] st);
        rx_frm_i = 1; rx_stat_i = st;
        if (m_ren[m_rh]) begin
            m_ren[m_rh] = 0; m_rdn[m_rh] = 1; m_rs[m_rh] = st; m_rh = (m_rh + 1) % 4;
        end else if (m_miss < 255) m_miss++;
        tick();
        rx_frm_i = 0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        reg_addr = 5'(a);
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_ta[i] = 0; m_ra[i] = 0; m_ts[i] = 0; m_rs[i] = 0; m_tl[i] = 0;
            m_ten[i] = 0; m_tdn[i] = 0; m_ren[i] = 0; m_rdn[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        tick();
        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd(s, 0, "R1 tx buf word");
            rd(12 + s, 0, "R1 rx buf word");
            rd(8 + s, 0, "R1 tx status");
        end
        rd(20, 0, "R1 irq enable");
        rd(21, 0, "R1 missed count");

        // R3/R4: single transmit slot
        wr(4, 32'd60);
        wr(0, 32'h0000_1001);
        tx_done(32'h0000_00A5);
        rd(0, 32'h0000_1006, "R2 R4 tx slot0 done, index 1");
        rd(8, 32'h0000_00A5, "R4 tx status captured");

        // R9: interrupt enable and acknowledge
        wr(20, 32'h1);
        rd(20, 32'h1, "R10 ctrl readback");
        wr(0, 32'h0000_1000);
        rd(0, 32'h0000_1004, "R2 done cleared by ack");

        // R5: no skipping past an unarmed slot
        wr(6, 32'd1514);
        wr(2, 32'h0000_3001);
        tx_done(32'hDEAD_0001);
        rd(0, buf_word(1, 0), "R5 index held at 1");
        rd(2, 32'h0000_3005, "R5 slot2 still armed");
        wr(5, 32'd64);
        wr(1, 32'h0000_2001);
        tx_done(32'h0000_0011);
        tx_done(32'h0000_0022);
        rd(0, 32'h0000_100C, "R4 tx index now 3");

        // R11: wrap
        wr(7, 32'd100);
        wr(3, 32'h0000_4001);
        wr(0, 32'h0000_5001);
        tx_done(32'h0000_0033);
        tx_done(32'h0000_0044);
        rd(3, buf_word(1, 3), "R11 tx index wrapped to 1");
        rd(8, 32'h0000_0044, "R11 slot0 status after wrap");

        // R2/R8: done-keep write and arm-clears-done
        wr(1, 32'h0000_6002);
        rd(1, 32'h0000_6006, "R2 done kept, address updated");
        wr(1, 32'h0000_6003);
        rd(1, 32'h0000_6005, "R8 arming clears done");

        // R7: receive with nothing armed
        rx_frm(32'h0000_0040);
        rd(21, 32'd1, "R7 missed count 1");
        rd(12, 32'h0, "R7 rx index held");

        // R6: armed receive ring
        for (int s = 0; s < 4; s++) wr(12 + s, 32'h0001_0001 + 32'(s) * 32'h100);
        for (int s = 0; s < 4; s++) rx_frm(32'h8000_0040 + 32'(s) * 32'h0100_0000 + 32'(s));
        for (int s = 0; s < 4; s++) rd(16 + s, m_rs[s], "R6 rx status captured");
        rd(12, buf_word(0, 0), "R6 R11 rx index wrapped");
        rx_frm(32'h0000_0050);
        rd(21, 32'd2, "R7 missed on exhausted ring");

        // R10: writes to read-only registers ignored
        wr(8, 32'hFFFF_FFFF);
        rd(8, m_ts[0], "R10 tx status not writable");
        wr(16, 32'hFFFF_FFFF);
        rd(16, m_rs[0], "R10 rx status not writable");
        wr(21, 32'h0000_0077);
        rd(21, 32'd2, "R10 missed count not writable");

        // R9: disable interrupt
        wr(20, 32'h0);

        // R7: saturation
        for (int i = 0; i < 300; i++) rx_frm(32'h0);
        rd(21, 32'd255, "R7 missed count saturates");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule